// File: doc/BRIEF.md
# Single-Bit Register with Mode-Mapped Asynchronous Controls

This block is one bit of storage with a clock, a clock enable and a synchronous data input. Two shared active-high asynchronous control lines, `ctl_a` and `ctl_b`, reach the bit through a mapping stage. A static 3-bit configuration code chooses what the lines do. The choices are clear, preset, both at once, or an asynchronous load of `ld_data` combined with clear, with preset, or with nothing else.

Some modes keep the stored bit inverted inside the block. In those modes a clear of the stored bit acts as a preset of the visible value, and the data paths into and out of the storage cell are inverted. The inversion is always undone at `q`, so `q` always shows the true logical value. A build parameter chooses how the preset-only mode is built: as an emulated preset through the inverted cell, or as a direct preset of the cell.

The block has no data stream, so it has no valid/ready handshake. All of its pins are plain control and data pins. The configuration code is meant to change only while `rst_n` is low.

Top module: `acr_reg`

## Requirements
- R1: While `rst_n` is low, `q` is 0 in every mode, including the modes that store the bit inverted.
- R2: While both control lines are low, a rising `clk` edge with `ena` high loads `d` into `q`, and a rising edge with `ena` low leaves `q` unchanged.
- R3: Mode code 0 is clear mode, and codes 6 and 7 behave the same way. In clear mode, either `ctl_a` or `ctl_b` forces `q` to 0.
- R4: Mode code 1 is preset mode. `ctl_a` forces `q` to 1, and `ctl_b` has no effect.
- R5: Mode code 2 is preset-and-clear mode. `ctl_a` alone forces `q` to 1, and `ctl_b` forces `q` to 0.
- R6: Mode code 3 is load-with-clear mode. `ctl_a` alone forces `q` to `ld_data`, and `ctl_b` forces `q` to 0.
- R7: Mode code 4 is load-with-preset mode. `ctl_a` alone forces `q` to `ld_data`. `ctl_b` forces `q` to 1, and this holds even when `ctl_a` is also high.
- R8: Mode code 5 is load-only mode. `ctl_a` forces `q` to `ld_data`, and `ctl_b` has no effect.
- R9: In modes 0 to 3, a clear request beats a simultaneous preset request, so `q` is 0. If the clear request drops while the preset request is still held, `q` stays 0 until the next rising `clk` edge.
- R10: The asynchronous controls act on `q` without any clock edge. After they are released, `q` keeps the forced value until the next enabled rising `clk` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; data is captured on the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset; forces `q` to 0 |
| ena | input | 1 | Clock enable for synchronous capture |
| d | input | 1 | Synchronous data input |
| mode | input | 3 | Static mode code for the control lines (0 to 5; 6 and 7 behave as 0) |
| ctl_a | input | 1 | Shared asynchronous control line A, active high |
| ctl_b | input | 1 | Shared asynchronous control line B, active high |
| ld_data | input | 1 | Value forced onto `q` by an asynchronous load |
| q | output | 1 | Stored bit, always shown as its true value |

## Verification
The asynchronous results arrive with no clock edge. The bench changes the control lines just after a falling edge and samples `q` one nanosecond later, well before the next rising edge. A synchronous capture is due at the first rising edge after the inputs are set up, so the bench reads it at the following falling edge. Control levels that the bench applies at random are held across one rising edge. This lets the clocked properties sample them, and it confirms that a forcing control overrides `ena` and `d` at that edge. The clear-priority and release-order sequences are applied and read back within half a clock period, so no edge falls inside them.

// File: rtl/acr_pkg.sv
package acr_pkg;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    M_CLR   = 3'd0,
    M_PRE   = 3'd1,
    M_PCLR  = 3'd2,
    M_LDCLR = 3'd3,
    M_LDPRE = 3'd4,
    M_LD    = 3'd5
  } mode_e;

  typedef struct packed {
    logic pre;
    logic clr;
    logic inv;
  } amap_t;
endpackage

// File: rtl/acr_map.sv
module acr_map
  import acr_pkg::*;
#(
  parameter bit PRE_EMULATE = 1'b1
) (
  input  logic [MODE_W-1:0] mode_i,
  input  logic              rst_ni,
  input  logic              a_i,
  input  logic              b_i,
  input  logic              ld_i,
  output amap_t             map_o
);
  amap_t pre_only;
  amap_t raw;

  generate
    if (PRE_EMULATE) begin : g_pre_emul
      always_comb begin
        pre_only     = '0;
        pre_only.inv = 1'b1;
        pre_only.clr = a_i;
      end
    end else begin : g_pre_direct
      always_comb begin
        pre_only     = '0;
        pre_only.pre = a_i;
      end
    end
  endgenerate

  always_comb begin
    raw = '0;
    case (mode_e'(mode_i))
      M_PRE:   raw = pre_only;
      M_PCLR: begin
        raw.pre = a_i;
        raw.clr = b_i;
      end
      M_LDCLR: begin
        raw.pre = a_i & ld_i;
        raw.clr = (a_i & ~ld_i) | b_i;
      end
      M_LDPRE: begin
        raw.inv = 1'b1;
        raw.pre = a_i & ~ld_i;
        raw.clr = (a_i & ld_i) | b_i;
      end
      M_LD: begin
        raw.pre = a_i & ld_i;
        raw.clr = a_i & ~ld_i;
      end
      default: raw.clr = a_i | b_i;
    endcase
  end

  always_comb begin
    map_o = raw;
    if (!rst_ni) begin
      map_o.pre = raw.inv;
      map_o.clr = ~raw.inv;
    end
  end
endmodule

// File: rtl/acr_cell.sv
module acr_cell (
  input  logic clk,
  input  logic ena,
  input  logic d,
  input  logic pre,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk or posedge clr or posedge pre) begin
    if (clr)      q <= 1'b0;
    else if (pre) q <= 1'b1;
    else if (ena) q <= d;
  end
endmodule

// File: rtl/acr_pol.sv
module acr_pol (
  input  logic inv,
  input  logic d_in,
  input  logic q_cell,
  output logic d_cell,
  output logic q_out
);
  assign d_cell = d_in ^ inv;
  assign q_out  = q_cell ^ inv;
endmodule

// File: rtl/acr_reg.sv
module acr_reg
  import acr_pkg::*;
#(
  parameter bit PRE_EMULATE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ena,
  input  logic              d,
  input  logic [MODE_W-1:0] mode,
  input  logic              ctl_a,
  input  logic              ctl_b,
  input  logic              ld_data,
  output logic              q
);
  amap_t map;
  logic  d_cell;
  logic  q_cell;
  logic  pre_s;
  logic  clr_s;

  acr_map #(.PRE_EMULATE(PRE_EMULATE)) u_map (
    .mode_i (mode),
    .rst_ni (rst_n),
    .a_i    (ctl_a),
    .b_i    (ctl_b),
    .ld_i   (ld_data),
    .map_o  (map)
  );

  assign pre_s = map.pre;
  assign clr_s = map.clr;

  acr_pol u_pol (
    .inv    (map.inv),
    .d_in   (d),
    .q_cell (q_cell),
    .d_cell (d_cell),
    .q_out  (q)
  );

  acr_cell u_cell (
    .clk (clk),
    .ena (ena),
    .d   (d_cell),
    .pre (pre_s),
    .clr (clr_s),
    .q   (q_cell)
  );
endmodule

// File: rtl/acr_reg_chk.sv
module acr_reg_chk
  import acr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              ena,
  input logic              d,
  input logic [MODE_W-1:0] mode,
  input logic              ctl_a,
  input logic              ctl_b,
  input logic              ld_data,
  input logic              q
);
  logic idle;
  assign idle = !ctl_a && !ctl_b;

  p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && ena) |=> (!idle || q == $past(d)));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !ena) |=> (!idle || $stable(q)));

  p_clear_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == 3'd0 || mode > 3'd5) && !idle) |-> q == 1'b0);

  p_preset_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd1 && ctl_a) |-> q == 1'b1);

  p_pre_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd2 && !idle) |-> q == !ctl_b);

  p_load_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd3 && !idle) |-> q == (ctl_b ? 1'b0 : ld_data));

  p_load_pre_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd4 && !idle) |-> q == (ctl_b ? 1'b1 : ld_data));

  p_load_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd5 && ctl_a) |-> q == ld_data);
endmodule

bind acr_reg acr_reg_chk u_chk (.*);

// File: tb/tb_acr_reg.sv
`timescale 1ns/100ps
module tb_acr_reg;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ena = 1'b0;
  logic       d = 1'b0;
  logic [2:0] mode = 3'd0;
  logic       ctl_a = 1'b0;
  logic       ctl_b = 1'b0;
  logic       ld_data = 1'b0;
  logic       q;

  int  n_run  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;
  logic exp_q;

  always #4 clk = ~clk;

  acr_reg dut (.*);

  function automatic logic [1:0] async_eval(logic [2:0] m, logic a, logic b, logic ld);
    case (m)
      3'd1: return {a, 1'b1};
      3'd2: return {a | b, ~b};
      3'd3: return {a | b, b ? 1'b0 : ld};
      3'd4: return {a | b, b ? 1'b1 : ld};
      3'd5: return {a, ld};
      default: return {a | b, 1'b0};
    endcase
  endfunction

  function automatic string mode_req(logic [2:0] m);
    case (m)
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4: return "R7";
      3'd5: return "R8";
      default: return "R3";
    endcase
  endfunction

  task automatic chk(string req, logic exp);
    n_run++;
    if (q !== exp) begin
      n_fail++;
      $display("FAIL %s: mode=%0d q=%b expected %b at %0t", req, mode, q, exp, $time);
    end
  endtask

  task automatic do_reset(logic [2:0] m);
    @(negedge clk);
    rst_n = 1'b0; ctl_a = 1'b0; ctl_b = 1'b0; ena = 1'b0;
    mode = m;
    #1 chk("R1", 1'b0);
    @(negedge clk);
    #1 chk("R1", 1'b0);
    rst_n = 1'b1;
    exp_q = 1'b0;
  endtask

  task automatic clk_step(logic e, logic dv);
    @(negedge clk);
    ena = e; d = dv; ctl_a = 1'b0; ctl_b = 1'b0;
    @(negedge clk);
    if (e) exp_q = dv;
    chk("R2", exp_q);
  endtask

  task automatic async_step(logic a, logic b, logic ld, logic e, logic dv);
    logic [1:0] r;
    r = async_eval(mode, a, b, ld);
    @(negedge clk);
    ena = e; d = dv; ld_data = ld; ctl_a = a; ctl_b = b;
    #1;
    if (r[1]) exp_q = r[0];
    chk(r[1] ? mode_req(mode) : "R10", exp_q);
    @(negedge clk);
    if (!r[1] && e) exp_q = dv;
    chk(r[1] ? mode_req(mode) : "R2", exp_q);
    ena = 1'b0;
    #1 ctl_a = 1'b0; ctl_b = 1'b0;
    #1 chk("R10", exp_q);
  endtask

  initial begin : watchdog
    #(8 * 150000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'h1f2e3d4c));
    exp_q = 1'b0;

    for (int m = 0; m < 8; m++) begin
      do_reset(3'(m));
      chk("R1", 1'b0);
      clk_step(1'b1, 1'b1);
      clk_step(1'b0, 1'b0);
      for (int i = 0; i < 250; i++) begin
        if ($urandom_range(0, 2) == 0)
          clk_step(1'($urandom), 1'($urandom));
        else
          async_step(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      end
    end

    // R3: codes 6 and 7 act as clear mode; ctl_b alone clears
    do_reset(3'd7);
    clk_step(1'b1, 1'b1);
    async_step(1'b0, 1'b1, 1'b1, 1'b1, 1'b1);

    // R4 / R8: ctl_b ignored, stored value kept
    do_reset(3'd1);
    clk_step(1'b1, 1'b1);
    async_step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    do_reset(3'd5);
    clk_step(1'b1, 1'b1);
    async_step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);

    // R7: both lines high gives 1 even with load data 0
    do_reset(3'd4);
    async_step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);

    // R9: preset then clear, release clear with preset held, all between edges
    for (int m = 2; m < 4; m++) begin
      do_reset(3'(m));
      @(negedge clk);
      ld_data = 1'b1;
      ctl_a = 1'b1;
      #0.5 chk(m == 2 ? "R5" : "R6", 1'b1);
      ctl_b = 1'b1;
      #0.5 chk("R9", 1'b0);
      ctl_b = 1'b0;
      #0.5 chk("R9", 1'b0);
      ctl_a = 1'b0;
      #0.5 chk("R9", 1'b0);
      exp_q = 1'b0;
      clk_step(1'b1, 1'b1);
    end

    // R10: forced value holds across a disabled edge after release
    do_reset(3'd5);
    async_step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    clk_step(1'b0, 1'b0);
    clk_step(1'b1, 1'b0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule